// File: doc/BRIEF.md
# Power Delivery Packet Transmitter

This block turns one USB Power Delivery style message into the line waveform for a single CC wire. A caller presents a 16-bit message header and up to a parameterised number of 32-bit data words, then pulses a start input. The block sends a training preamble and a start-of-packet ordered set. It then sends the header and the data words as 4b/5b symbols, a CRC-32 over header and data, and an end-of-packet symbol. Every bit is biphase-mark coded, and the frame closes with one extra line edge.

A second request input sends the hard-reset ordered set in place of a message. That frame has no header, payload, CRC or end symbol. One clock period equals one half-bit cell. The line output therefore drives an analog driver directly, and the busy and done outputs tell the caller when it may queue the next frame. Collision sensing, retries and acknowledgement handling belong to the caller.

Top module: `pd_bmc_tx`

## Requirements
- R1: After reset, and at any time no frame is in progress, `line_out`, `busy` and `done` are all low. Asserting `rst_n` low in the middle of a frame returns all three to low.
- R2: Every frame opens with a preamble of `PREAMBLE_BITS` (default 64) raw bits that alternate 0,1,0,1,… and start with 0.
- R3: A message frame continues with Sync-1, Sync-1, Sync-1, Sync-2. Codes are written MSB..LSB, and every 5-bit symbol is sent bit 0 first. The K-codes are Sync-1=11000, Sync-2=10001, RST-1=00111, RST-2=11001 and EOP=01101. Data nibbles are coded 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R4: After the ordered set come the four header nibbles, least significant first. Then come N data words, each as eight nibbles with the least significant nibble first, so the low half goes before the high half. N is header bits [14:12], clamped to `MAX_WORDS`. Payload words at index N and above are not sent.
- R5: After the payload come eight nibbles of a CRC-32, least significant first, then the EOP symbol. The CRC uses the reflected polynomial 0xEDB88320 with initial value 0xFFFFFFFF and a final inversion. It covers the header and the sent data words in transmission order.
- R6: Each raw bit takes two clocks. The line inverts at the start of every bit, and inverts again at the middle of a 1 bit. The line level before the first bit is low. The first half-bit cell shows on `line_out` in the second clock after the request is sampled.
- R7: After the last bit, the line inverts for exactly one extra half-bit cell. During that cell `done` is high and `busy` is low. In the next clock the line is low and `done` is low.
- R8: A hard-reset request sends the preamble, RST-1, RST-1, RST-1, RST-2 and the closing edge, and nothing else. If both requests arrive in the same clock, the hard reset is sent.
- R9: Requests that arrive while `busy` is high are ignored. The frame in flight goes on unchanged, and no second frame follows it.
- R10: `busy` rises in the clock after an accepted request and stays high until the closing cell. `done` is a single-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per half-bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start | input | 1 | Request to send a message frame |
| hard_reset_start | input | 1 | Request to send the hard-reset ordered set |
| msg_header | input | 16 | Message header, sampled with the request |
| msg_payload | input | 32*MAX_WORDS | Data words, word k in bits [32k+31:32k], sampled with the request |
| line_out | output | 1 | Coded line level |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse during the closing cell |

## Verification
Messages with zero, one, three and seven data words exercise the nibble ordering and the CRC across different lengths. A header whose count is zero but whose payload is non-zero shows that unsent words stay out of both the stream and the CRC. Each received stream is compared section by section against a bench-built waveform: preamble, ordered set, body, CRC with end symbol, and closing cell. A fault can therefore be traced to the coding step it belongs to. Directed cases cover a lone hard reset, both requests in the same clock, requests that land mid-frame, and a reset during transmission.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SOP,
        PH_HDR,
        PH_DATA,
        PH_CRC,
        PH_EOP,
        PH_TAIL
    } tx_phase_e;

    localparam logic [4:0] K_SYNC1 = 5'b11000;
    localparam logic [4:0] K_SYNC2 = 5'b10001;
    localparam logic [4:0] K_RST1  = 5'b00111;
    localparam logic [4:0] K_RST2  = 5'b11001;
    localparam logic [4:0] K_EOP   = 5'b01101;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    function automatic logic [4:0] nib_to_sym(input logic [3:0] n);
        logic [4:0] s;
        unique case (n)
            4'h0: s = 5'b11110;
            4'h1: s = 5'b01001;
            4'h2: s = 5'b10100;
            4'h3: s = 5'b10101;
            4'h4: s = 5'b01010;
            4'h5: s = 5'b01011;
            4'h6: s = 5'b01110;
            4'h7: s = 5'b01111;
            4'h8: s = 5'b10010;
            4'h9: s = 5'b10011;
            4'hA: s = 5'b10110;
            4'hB: s = 5'b10111;
            4'hC: s = 5'b11010;
            4'hD: s = 5'b11011;
            4'hE: s = 5'b11100;
            default: s = 5'b11101;
        endcase
        return s;
    endfunction

    // advance a reflected CRC-32 by four input bits, bit 0 first
    function automatic logic [31:0] crc_nib_step(input logic [31:0] c, input logic [3:0] n);
        logic [31:0] r;
        r = c ^ {28'd0, n};
        for (int k = 0; k < 4; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pd_crc32_nib.sv
module pd_crc32_nib
    import pd_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [3:0]  nib,
    output logic [31:0] crc
);

    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr) begin
            crc_d = CRC_SEED;
        end else if (en) begin
            crc_d = crc_nib_step(crc_q, nib);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

endmodule

// File: rtl/pd_bmc_line.sv
module pd_bmc_line (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tail,
    input  logic bit_in,
    output logic line,
    output logic bit_end
);

    typedef struct packed {
        logic line;
        logic half;
    } line_st_t;

    line_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!active) begin
            s_d.line = 1'b0;
            s_d.half = 1'b0;
        end else if (tail) begin
            s_d.line = ~s_q.line;
            s_d.half = 1'b0;
        end else if (!s_q.half) begin
            s_d.line = ~s_q.line;
            s_d.half = 1'b1;
        end else begin
            s_d.line = bit_in ? ~s_q.line : s_q.line;
            s_d.half = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign line    = s_q.line;
    assign bit_end = active & (tail | s_q.half);

    // R6
    bit_start_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tail && !s_q.half) |=> (s_q.line != $past(s_q.line)));

    // R6
    zero_mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tail && s_q.half && !bit_in) |=> $stable(s_q.line));

endmodule

// File: rtl/pd_tx_seq.sv
module pd_tx_seq
    import pd_tx_pkg::*;
#(
    parameter int MAX_WORDS     = 7,
    parameter int PREAMBLE_BITS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    msg_go,
    input  logic                    hr_go,
    input  logic [15:0]             hdr_in,
    input  logic [MAX_WORDS*32-1:0] pay_in,
    input  logic [31:0]             crc_in,
    input  logic                    bit_end,
    output logic                    crc_clr,
    output logic                    crc_en,
    output logic [3:0]              crc_nib,
    output logic                    active,
    output logic                    tail,
    output logic                    bit_out,
    output logic                    busy,
    output logic                    done
);

    localparam int PAY_W = MAX_WORDS * 32;
    localparam int CW    = $clog2(MAX_WORDS + 1);
    localparam int CNT_W = $clog2(PREAMBLE_BITS + 8 * MAX_WORDS + 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PREAMBLE_BITS - 1);

    typedef struct packed {
        tx_phase_e        phase;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       bpos;
        logic [4:0]       sym;
        logic             hr;
        logic [CW-1:0]    nwords;
        logic [15:0]      hdr;
        logic [PAY_W-1:0] pay;
        logic             done;
    } seq_st_t;

    seq_st_t          s_d, s_q;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] data_last;
    logic [CW-1:0]    nw_in;
    logic [31:0]      crc_fin;
    int unsigned      raw_cnt;

    always_comb begin
        raw_cnt = 32'(hdr_in[14:12]);
        nw_in   = (raw_cnt > 32'(MAX_WORDS)) ? CW'(MAX_WORDS) : CW'(raw_cnt);
    end

    assign crc_fin   = ~crc_in;
    assign nxt       = s_q.cnt + 1'b1;
    assign data_last = CNT_W'({s_q.nwords - 1'b1, 3'b111});

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        crc_nib  = 4'h0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (hr_go || msg_go) begin
                    s_d.phase  = PH_PRE;
                    s_d.cnt    = '0;
                    s_d.bpos   = '0;
                    s_d.hr     = hr_go;
                    s_d.hdr    = hdr_in;
                    s_d.pay    = pay_in;
                    s_d.nwords = nw_in;
                    crc_clr    = 1'b1;
                end
            end
            PH_PRE: begin
                if (bit_end) begin
                    if (s_q.cnt == PRE_LAST) begin
                        s_d.phase = PH_SOP;
                        s_d.cnt   = '0;
                        s_d.bpos  = '0;
                        s_d.sym   = s_q.hr ? K_RST1 : K_SYNC1;
                    end else begin
                        s_d.cnt = nxt;
                    end
                end
            end
            PH_TAIL: begin
                if (bit_end) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: begin
                if (bit_end) begin
                    if (s_q.bpos != 3'd4) begin
                        s_d.bpos = s_q.bpos + 1'b1;
                    end else begin
                        s_d.bpos = '0;
                        unique case (s_q.phase)
                            PH_SOP: begin
                                if (s_q.cnt != CNT_W'(3)) begin
                                    s_d.cnt = nxt;
                                    if (nxt == CNT_W'(3)) s_d.sym = s_q.hr ? K_RST2 : K_SYNC2;
                                    else                  s_d.sym = s_q.hr ? K_RST1 : K_SYNC1;
                                end else if (s_q.hr) begin
                                    s_d.phase = PH_TAIL;
                                end else begin
                                    s_d.phase = PH_HDR;
                                    s_d.cnt   = '0;
                                    crc_en    = 1'b1;
                                    crc_nib   = s_q.hdr[3:0];
                                end
                            end
                            PH_HDR: begin
                                if (s_q.cnt != CNT_W'(3)) begin
                                    s_d.cnt = nxt;
                                    crc_en  = 1'b1;
                                    crc_nib = s_q.hdr[{nxt[1:0], 2'b00} +: 4];
                                end else if (s_q.nwords != '0) begin
                                    s_d.phase = PH_DATA;
                                    s_d.cnt   = '0;
                                    crc_en    = 1'b1;
                                    crc_nib   = s_q.pay[3:0];
                                end else begin
                                    s_d.phase = PH_CRC;
                                    s_d.cnt   = '0;
                                    s_d.sym   = nib_to_sym(crc_fin[3:0]);
                                end
                            end
                            PH_DATA: begin
                                if (s_q.cnt != data_last) begin
                                    s_d.cnt = nxt;
                                    crc_en  = 1'b1;
                                    crc_nib = s_q.pay[4 * int'(nxt) +: 4];
                                end else begin
                                    s_d.phase = PH_CRC;
                                    s_d.cnt   = '0;
                                    s_d.sym   = nib_to_sym(crc_fin[3:0]);
                                end
                            end
                            PH_CRC: begin
                                if (s_q.cnt != CNT_W'(7)) begin
                                    s_d.cnt = nxt;
                                    s_d.sym = nib_to_sym(crc_fin[{nxt[2:0], 2'b00} +: 4]);
                                end else begin
                                    s_d.phase = PH_EOP;
                                    s_d.sym   = K_EOP;
                                end
                            end
                            PH_EOP: begin
                                s_d.phase = PH_TAIL;
                            end
                            default: ;
                        endcase
                        if (crc_en) s_d.sym = nib_to_sym(crc_nib);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = (s_q.phase != PH_IDLE);
    assign tail    = (s_q.phase == PH_TAIL);
    assign bit_out = (s_q.phase == PH_PRE) ? s_q.cnt[0] : s_q.sym[s_q.bpos];
    assign busy    = active;
    assign done    = s_q.done;

    // R3
    bpos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bpos <= 3'd4);

    // R9
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |=> $stable(s_q.hdr));

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(msg_go || hr_go));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/pd_bmc_tx.sv
module pd_bmc_tx #(
    parameter int MAX_WORDS     = 7,
    parameter int PREAMBLE_BITS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    msg_start,
    input  logic                    hard_reset_start,
    input  logic [15:0]             msg_header,
    input  logic [MAX_WORDS*32-1:0] msg_payload,
    output logic                    line_out,
    output logic                    busy,
    output logic                    done
);

    logic        crc_clr, crc_en;
    logic [3:0]  crc_nib;
    logic [31:0] crc_val;
    logic        active, tail, bit_val, bit_end;

    pd_tx_seq #(
        .MAX_WORDS     (MAX_WORDS),
        .PREAMBLE_BITS (PREAMBLE_BITS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .msg_go  (msg_start),
        .hr_go   (hard_reset_start),
        .hdr_in  (msg_header),
        .pay_in  (msg_payload),
        .crc_in  (crc_val),
        .bit_end (bit_end),
        .crc_clr (crc_clr),
        .crc_en  (crc_en),
        .crc_nib (crc_nib),
        .active  (active),
        .tail    (tail),
        .bit_out (bit_val),
        .busy    (busy),
        .done    (done)
    );

    pd_crc32_nib u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .nib   (crc_nib),
        .crc   (crc_val)
    );

    pd_bmc_line u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .tail    (tail),
        .bit_in  (bit_val),
        .line    (line_out),
        .bit_end (bit_end)
    );

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> !line_out);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/pd_bmc_tx_tb.sv
module pd_bmc_tx_tb;

    localparam int MAXW = 7;
    localparam int PAYW = MAXW * 32;
    localparam int NVEC = 5;
    localparam logic [15:0] VEC_HDR  [0:NVEC-1] = '{16'h0A61, 16'h1A42, 16'h3C83, 16'h7FFF, 16'h8F0E};
    localparam logic [31:0] VEC_SEED [0:NVEC-1] = '{32'h00000000, 32'hDEADBEEF, 32'h12345678, 32'hA5A5F00F, 32'h0BADCAFE};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msg_start = 1'b0;
    logic hard_reset_start = 1'b0;
    logic [15:0] hdr = '0;
    logic [PAYW-1:0] pay = '0;
    logic line_out, busy, done;

    always #10 clk = ~clk;

    pd_bmc_tx #(.MAX_WORDS(MAXW), .PREAMBLE_BITS(64)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .msg_start        (msg_start),
        .hard_reset_start (hard_reset_start),
        .msg_header       (hdr),
        .msg_payload      (pay),
        .line_out         (line_out),
        .busy             (busy),
        .done             (done)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic xb [0:511];
    int   nb;
    logic exp_c [0:1023];
    logic act_c [0:1023];
    int   n_exp;
    int   mark [0:4];

    task automatic chk(input bit ok, input string tag, input string what, input int a, input int e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, a, e);
        end
    endtask

    function automatic logic [4:0] code5(input logic [3:0] n);
        logic [4:0] t [0:15];
        t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
              5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic add_sym(input logic [4:0] s);
        for (int k = 0; k < 5; k++) begin
            xb[nb] = s[k];
            nb++;
        end
    endtask

    task automatic build_exp(input logic [15:0] h, input logic [PAYW-1:0] p, input bit hr);
        int nw;
        logic [31:0] c;
        logic lv;
        nb = 0;
        nw = int'(h[14:12]);
        for (int i = 0; i < 64; i++) begin
            xb[nb] = i[0];
            nb++;
        end
        mark[0] = 2 * nb;
        if (hr) begin
            add_sym(5'b00111); add_sym(5'b00111); add_sym(5'b00111); add_sym(5'b11001);
            mark[1] = 2 * nb; mark[2] = 2 * nb; mark[3] = 2 * nb;
        end else begin
            add_sym(5'b11000); add_sym(5'b11000); add_sym(5'b11000); add_sym(5'b10001);
            mark[1] = 2 * nb;
            c = 32'hFFFFFFFF;
            c = crc_byte(c, h[7:0]);
            c = crc_byte(c, h[15:8]);
            for (int k = 0; k < 4; k++) add_sym(code5(h[4*k +: 4]));
            for (int w = 0; w < nw; w++) begin
                for (int k = 0; k < 4; k++) c = crc_byte(c, p[32*w + 8*k +: 8]);
                for (int k = 0; k < 8; k++) add_sym(code5(p[32*w + 4*k +: 4]));
            end
            mark[2] = 2 * nb;
            c = ~c;
            for (int k = 0; k < 8; k++) add_sym(code5(c[4*k +: 4]));
            add_sym(5'b01101);
            mark[3] = 2 * nb;
        end
        lv = 1'b0;
        n_exp = 0;
        for (int i = 0; i < nb; i++) begin
            lv = ~lv;
            exp_c[n_exp] = lv; n_exp++;
            if (xb[i]) lv = ~lv;
            exp_c[n_exp] = lv; n_exp++;
        end
        exp_c[n_exp] = ~lv;
        n_exp++;
        mark[4] = n_exp;
    endtask

    task automatic cmp_range(input int lo, input int hi, input string tag, input string what);
        int first;
        first = -1;
        for (int i = lo; i < hi; i++) begin
            if (first < 0 && act_c[i] !== exp_c[i]) first = i;
        end
        if (first < 0) chk(1'b1, tag, what, 0, 0);
        else chk(1'b0, tag, $sformatf("%s cell %0d", what, first), int'(act_c[first]), int'(exp_c[first]));
    endtask

    task automatic run_frame(input logic [15:0] h, input logic [PAYW-1:0] p,
                             input bit ms, input bit hs, input bit poke, input string tag);
        build_exp(h, p, hs);
        @(negedge clk);
        hdr = h; pay = p; msg_start = ms; hard_reset_start = hs;
        @(negedge clk);
        msg_start = 1'b0; hard_reset_start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after request", int'(busy), 1);
        for (int i = 0; i < n_exp; i++) begin
            @(negedge clk);
            act_c[i] = line_out;
            if (i == n_exp - 1) begin
                chk(done == 1'b1 && busy == 1'b0, "R7", "done/busy in closing cell",
                    int'({done, busy}), 2);
            end
            if (poke && i == 150) begin
                msg_start = 1'b1; hard_reset_start = 1'b1; hdr = 16'h7123; pay = ~p;
            end
            if (poke && i == 151) begin
                msg_start = 1'b0; hard_reset_start = 1'b0;
            end
        end
        @(negedge clk);
        chk(line_out == 1'b0 && done == 1'b0, "R7", "line and done after closing cell",
            int'({line_out, done}), 0);
        @(negedge clk);
        chk(busy == 1'b0 && line_out == 1'b0, "R1", "idle after frame", int'({busy, line_out}), 0);
        cmp_range(0, mark[0], "R2", {tag, " preamble"});
        cmp_range(mark[0], mark[1], hs ? "R8" : "R3", {tag, " ordered set"});
        if (!hs) begin
            cmp_range(mark[1], mark[2], "R4", {tag, " header and payload"});
            cmp_range(mark[2], mark[3], "R5", {tag, " crc and eop"});
        end
        cmp_range(0, n_exp, poke ? "R9" : "R6", {tag, " whole waveform"});
    endtask

    function automatic logic [PAYW-1:0] mk_pay(input logic [31:0] seed);
        logic [PAYW-1:0] r;
        for (int w = 0; w < MAXW; w++) begin
            r[32*w +: 32] = seed ^ (32'(w + 1) * 32'h9E3779B9) ^ {8'(w), 24'h3C5A69};
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(line_out == 1'b0 && busy == 1'b0 && done == 1'b0, "R1", "outputs in reset",
            int'({line_out, busy, done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(line_out == 1'b0 && busy == 1'b0 && done == 1'b0, "R1", "outputs idle after reset",
            int'({line_out, busy, done}), 0);

        // table walk: R2..R6 across payload lengths 0,1,3,7 and count 0 with data present
        for (int v = 0; v < NVEC; v++) begin
            run_frame(VEC_HDR[v], mk_pay(VEC_SEED[v]), 1'b1, 1'b0, 1'b0, $sformatf("vec%0d", v));
        end

        // R8: lone hard reset
        run_frame(16'h1234, mk_pay(32'h1), 1'b0, 1'b1, 1'b0, "hard reset");
        chk(n_exp == 169, "R8", "hard reset cell count", n_exp, 169);

        // R8: both requests together, hard reset wins
        run_frame(16'h2222, mk_pay(32'h2), 1'b1, 1'b1, 1'b0, "both requests");

        // R9: requests during a frame are ignored
        run_frame(16'h3333, mk_pay(32'h3), 1'b1, 1'b0, 1'b1, "mid-frame request");
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && line_out == 1'b0, "R9", "no second frame", int'({busy, line_out}), 0);

        // R1: reset during transmission
        @(negedge clk);
        hdr = 16'h1A42; pay = mk_pay(32'h4); msg_start = 1'b1;
        @(negedge clk);
        msg_start = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(line_out == 1'b0 && busy == 1'b0 && done == 1'b0, "R1", "outputs after mid-frame reset",
            int'({line_out, busy, done}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && line_out == 1'b0, "R1", "idle after reset release", int'({busy, line_out}), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule